// File: doc/BRIEF.md
# Translation Cache with Flush and Single-Page Invalidation

This block is a small fully associative cache of page translations that sits between an address requester and a page table walker. It covers 4 KB pages. A 32-bit virtual address splits into a 20-bit virtual page number and a 12-bit offset. The block compares the page number with every valid entry in the same cycle. On a hit it answers at once with the cached 20-bit physical frame joined to the unchanged offset. It also reports a fault when the cached permissions refuse the access.

On a miss the block raises a walk request that carries the page number. The requester holds its lookup until the walker answers. A successful answer goes back to the requester in that same cycle and is also written into the cache at the next clock edge, with no software involvement. A walker fault goes back to the requester and is never stored.

Two invalidation paths keep the cache coherent with the page tables:
- A write to the translation root pointer clears every entry.
- A single-page invalidate clears only the entry whose page number matches the given address.

Top module: `xlat_cache`

## Requirements
- R1: On a lookup that hits, `lk_hit` and `lk_done` rise in the same cycle. `lk_paddr` is the cached frame in bits 31:12 and the unchanged `lk_vaddr[11:0]` in bits 11:0.
- R2: On a lookup that misses:
  - `walk_req` is 1 and `walk_vpn` equals `lk_vaddr[31:12]`.
  - `lk_done` stays 0 until `walk_done` is 1.
  - In that cycle `lk_paddr` is `{walk_ppn, offset}`.
- R3: A walk answer with `walk_fault` = 0 is stored at the next edge. A later lookup of that page then hits with the same frame. A page is never held in two entries.
- R4: A walk answer with `walk_fault` = 1 sets `lk_fault`. It is not stored, so a later lookup of that page misses.
- R5: Permission field encoding is bit 0 present, bit 1 writable, bit 2 user. An access faults when any of these holds:
  - the present bit is 0;
  - `lk_user` is set and the user bit is 0;
  - `lk_write` is set, the writable bit is 0, and either `lk_user` or `lk_wp` is set.
  A hit that faults this way raises no walk request.
- R6: A cycle with `root_write` = 1 empties every entry at the next edge.
- R7: `inv_valid` with `inv_vaddr` removes only the entry whose page number equals `inv_vaddr[31:12]`. All other entries stay, and a non-matching address changes nothing.
- R8: Slot choice for a new entry:
  - A new entry goes to the lowest free slot.
  - When all 8 slots are valid, the entry replaces slots in round-robin order.
  - A flush returns the round-robin pointer to slot 0.
- R9: When an invalidation that matches the page being stored, or a flush, falls in the same cycle as a store, the invalidation wins and the page is not stored.
- R10: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request, held until `lk_done` |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup comes from user privilege |
| lk_wp | input | 1 | Supervisor writes honour the writable bit |
| lk_done | output | 1 | Lookup answered this cycle |
| lk_hit | output | 1 | Answer came from the cache |
| lk_fault | output | 1 | Translation or permission fault |
| lk_paddr | output | 32 | Physical address |
| walk_req | output | 1 | Walk request on a miss |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walker answer valid |
| walk_fault | input | 1 | Walker found no translation |
| walk_ppn | input | 20 | Frame from the walker |
| walk_perm | input | 3 | Effective permissions from the walker {user, writable, present} |
| root_write | input | 1 | Root pointer written: flush all |
| inv_valid | input | 1 | Single-page invalidate |
| inv_vaddr | input | 32 | Address to invalidate |

## Verification
A fill from a returning walk can fall in the same edge as a single-page invalidate or a root-pointer flush. The bench drives `walk_done` together with `inv_valid` or `root_write` in one cycle. It checks three pairings:
- the invalidated address equal to the page being stored;
- an unrelated address that is already cached;
- a flush.

After each, per-page probes must show the stored page absent when the two collide. Unrelated entries must show exactly the changes the invalidation asked for.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VPN_W = 20;
  localparam int PPN_W = 20;
  localparam int OFF_W = 12;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  typedef struct packed {
    logic usr;
    logic wrt;
    logic prs;
  } perm_t;
endpackage

// File: rtl/xlat_slot.sv
module xlat_slot
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  perm_t            wr_perm,
  input  logic [VPN_W-1:0] cmp_vpn,
  output logic             match,
  output logic             vld,
  output logic [PPN_W-1:0] ppn,
  output perm_t            perm
);
  logic             vld_q, vld_d;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  perm_t            perm_q;
  logic [VPN_W-1:0] next_vpn;

  assign next_vpn = wr_en ? wr_vpn : vpn_q;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d = 1'b1;
    if (inv_en && (next_vpn == inv_vpn)) vld_d = 1'b0;
    if (flush) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q  <= wr_vpn;
      ppn_q  <= wr_ppn;
      perm_q <= wr_perm;
    end
  end

  assign match = vld_q && (vpn_q == cmp_vpn);
  assign vld   = vld_q;
  assign ppn   = ppn_q;
  assign perm  = perm_q;
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int NENT  = 8,
  parameter int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NENT-1:0]  vld_vec,
  input  logic             fill,
  input  logic             flush,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rr_q, rr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (!vld_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (flush)
      rr_d = '0;
    else if (fill && !any_free)
      rr_d = (rr_q == IDX_W'(NENT - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  perm_t perm,
  input  logic  user,
  input  logic  write,
  input  logic  wp,
  output logic  fault
);
  logic no_prs, no_usr, no_wrt;

  assign no_prs = !perm.prs;
  assign no_usr = user && !perm.usr;
  assign no_wrt = write && !perm.wrt && (user || wp);
  assign fault  = no_prs || no_usr || no_wrt;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int NENT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              lk_write,
  input  logic              lk_user,
  input  logic              lk_wp,
  output logic              lk_done,
  output logic              lk_hit,
  output logic              lk_fault,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              walk_done,
  input  logic              walk_fault,
  input  logic [PPN_W-1:0]  walk_ppn,
  input  logic [2:0]        walk_perm,
  input  logic              root_write,
  input  logic              inv_valid,
  input  logic [VA_W-1:0]   inv_vaddr
);
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;

  logic [VPN_W-1:0] lk_vpn, inv_vpn;
  logic [OFF_W-1:0] lk_off;
  logic [NENT-1:0]  hit_vec, vld_vec, wr_vec;
  logic [PPN_W-1:0] slot_ppn  [NENT];
  perm_t            slot_perm [NENT];
  logic [PPN_W-1:0] hit_ppn;
  perm_t            hit_perm, chk_perm, wk_perm;
  logic             any_hit, miss, fill_en, perm_fault;
  logic [IDX_W-1:0] victim;

  assign lk_vpn  = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off  = lk_vaddr[OFF_W-1:0];
  assign inv_vpn = inv_vaddr[VA_W-1:OFF_W];
  assign wk_perm = perm_t'(walk_perm);

  for (genvar g = 0; g < NENT; g++) begin : g_slot
    assign wr_vec[g] = fill_en && (victim == IDX_W'(g));
    xlat_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (root_write),
      .inv_en  (inv_valid),
      .inv_vpn (inv_vpn),
      .wr_en   (wr_vec[g]),
      .wr_vpn  (lk_vpn),
      .wr_ppn  (walk_ppn),
      .wr_perm (wk_perm),
      .cmp_vpn (lk_vpn),
      .match   (hit_vec[g]),
      .vld     (vld_vec[g]),
      .ppn     (slot_ppn[g]),
      .perm    (slot_perm[g])
    );
  end

  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < NENT; i++) begin
      if (hit_vec[i]) begin
        hit_ppn  = hit_ppn | slot_ppn[i];
        hit_perm = hit_perm | slot_perm[i];
      end
    end
  end

  xlat_victim #(.NENT(NENT), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld_vec (vld_vec),
    .fill    (fill_en),
    .flush   (root_write),
    .victim  (victim)
  );

  assign any_hit  = |hit_vec;
  assign miss     = lk_valid && !any_hit;
  assign fill_en  = miss && walk_done && !walk_fault;
  assign chk_perm = any_hit ? hit_perm : wk_perm;

  xlat_perm u_perm (
    .perm  (chk_perm),
    .user  (lk_user),
    .write (lk_write),
    .wp    (lk_wp),
    .fault (perm_fault)
  );

  assign lk_hit   = lk_valid && any_hit;
  assign lk_done  = lk_hit || (miss && walk_done);
  assign lk_fault = lk_done && ((miss && walk_fault) || perm_fault);
  assign lk_paddr = {(any_hit ? hit_ppn : walk_ppn), lk_off};
  assign walk_req = miss;
  assign walk_vpn = lk_vpn;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk
  import xlat_pkg::*;
#(
  parameter int NENT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic             lk_done,
  input logic             lk_hit,
  input logic             lk_fault,
  input logic [PA_W-1:0]  lk_paddr,
  input logic             walk_req,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             walk_done,
  input logic             walk_fault,
  input logic             root_write,
  input logic             inv_valid,
  input logic [VA_W-1:0]  inv_vaddr,
  input logic [NENT-1:0]  hit_vec
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_done && lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  // R2
  miss_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> (!lk_hit && lk_valid && lk_done == walk_done
                  && walk_vpn == lk_vaddr[VA_W-1:OFF_W]));

  // R3
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R4
  walk_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_done && walk_fault) |-> lk_fault);

  // R6
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    root_write |=> !lk_hit);

  // R7
  inv_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_hit && lk_vaddr[VA_W-1:OFF_W] == $past(inv_vaddr[VA_W-1:OFF_W])));
endmodule

bind xlat_cache xlat_cache_chk #(.NENT(NENT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_done    (lk_done),
  .lk_hit     (lk_hit),
  .lk_fault   (lk_fault),
  .lk_paddr   (lk_paddr),
  .walk_req   (walk_req),
  .walk_vpn   (walk_vpn),
  .walk_done  (walk_done),
  .walk_fault (walk_fault),
  .root_write (root_write),
  .inv_valid  (inv_valid),
  .inv_vaddr  (inv_vaddr),
  .hit_vec    (hit_vec)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  logic        clk, rst_n;
  logic        lk_valid, lk_write, lk_user, lk_wp;
  logic [31:0] lk_vaddr, inv_vaddr;
  logic        lk_done, lk_hit, lk_fault;
  logic [31:0] lk_paddr;
  logic        walk_req, walk_done, walk_fault;
  logic [19:0] walk_vpn, walk_ppn;
  logic [2:0]  walk_perm;
  logic        root_write, inv_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  xlat_cache dut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return v ^ 20'h5A3C1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_user = 0; lk_wp = 0; lk_vaddr = 0;
    walk_done = 0; walk_fault = 0; walk_ppn = 0; walk_perm = 0;
    root_write = 0; inv_valid = 0; inv_vaddr = 0;
  endtask

  // lookup without a walker answer: no state change
  task automatic probe(input logic [19:0] vpn, input logic [11:0] off,
                       input bit wr, input bit usr, input bit wp,
                       output bit hit, output bit flt, output logic [31:0] pa, output bit wreq);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {vpn, off}; lk_write = wr; lk_user = usr; lk_wp = wp;
    #1;
    hit = lk_hit; flt = lk_fault; pa = lk_paddr; wreq = walk_req;
    idle();
  endtask

  task automatic expect_hit(input logic [19:0] vpn, input bit exp, input string req);
    bit h, f, w; logic [31:0] pa;
    probe(vpn, 12'h3C5, 0, 0, 0, h, f, pa, w);
    chk(h == exp, req, {31'd0, h}, {31'd0, exp});
    if (exp && h) chk(pa == {ppn_of(vpn), 12'h3C5}, req, pa, {ppn_of(vpn), 12'h3C5});
  endtask

  // miss then walker answer in one cycle, optional collision
  task automatic fill(input logic [19:0] vpn, input logic [2:0] perm, input bit wf,
                      input bit do_inv, input logic [19:0] ivpn, input bit do_flush,
                      output bit flt, output logic [31:0] pa);
    @(negedge clk);
    lk_valid = 1; lk_vaddr = {vpn, 12'h010};
    walk_done = 1; walk_fault = wf; walk_ppn = ppn_of(vpn); walk_perm = perm;
    inv_valid = do_inv; inv_vaddr = {ivpn, 12'hFFF}; root_write = do_flush;
    #1;
    flt = lk_fault; pa = lk_paddr;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic fill_ok(input logic [19:0] vpn);
    bit f; logic [31:0] pa;
    fill(vpn, 3'b111, 0, 0, 0, 0, f, pa);
  endtask

  task automatic flush();
    @(negedge clk); root_write = 1;
    @(posedge clk); #1; idle();
  endtask

  task automatic inval(input logic [19:0] vpn);
    @(negedge clk); inv_valid = 1; inv_vaddr = {vpn, 12'h123};
    @(posedge clk); #1; idle();
  endtask

  initial begin
    bit h, f, w; logic [31:0] pa;
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset state
    for (int i = 0; i < 4; i++) expect_hit(20'h00000 + 20'(i * 7), 0, "R10");

    // R2 miss waits for walker
    @(negedge clk);
    lk_valid = 1; lk_vaddr = 32'hF0001ABC;
    #1;
    chk(walk_req == 1, "R2 req", {31'd0, walk_req}, 32'd1);
    chk(walk_vpn == 20'hF0001, "R2 vpn", {12'd0, walk_vpn}, 32'hF0001);
    chk(lk_done == 0, "R2 wait", {31'd0, lk_done}, 32'd0);
    @(negedge clk);
    walk_done = 1; walk_ppn = ppn_of(20'hF0001); walk_perm = 3'b111;
    #1;
    chk(lk_done == 1 && lk_hit == 0, "R2 done", {30'd0, lk_done, lk_hit}, 32'd2);
    chk(lk_paddr == {ppn_of(20'hF0001), 12'hABC}, "R2 paddr", lk_paddr, {ppn_of(20'hF0001), 12'hABC});
    @(posedge clk); #1; idle();

    // R1 R3 hit after fill
    probe(20'hF0001, 12'h7E4, 0, 0, 0, h, f, pa, w);
    chk(h == 1 && w == 0, "R1 hit", {30'd0, h, w}, 32'd2);
    chk(pa == {ppn_of(20'hF0001), 12'h7E4}, "R1 paddr", pa, {ppn_of(20'hF0001), 12'h7E4});
    expect_hit(20'hF0001, 1, "R3");

    // R4 walker fault
    fill(20'h12345, 3'b111, 1, 0, 0, 0, f, pa);
    chk(f == 1, "R4 fault", {31'd0, f}, 32'd1);
    expect_hit(20'h12345, 0, "R4 not stored");

    // R6 flush
    flush();
    expect_hit(20'hF0001, 0, "R6");

    // R8 replacement order
    for (int i = 0; i < 8; i++) fill_ok(20'h00100 + 20'(i));
    for (int i = 0; i < 8; i++) expect_hit(20'h00100 + 20'(i), 1, "R8 fill");
    fill_ok(20'h00200);
    expect_hit(20'h00100, 0, "R8 evict0");
    expect_hit(20'h00101, 1, "R8 keep1");
    expect_hit(20'h00200, 1, "R8 new");
    fill_ok(20'h00201);
    expect_hit(20'h00101, 0, "R8 evict1");
    expect_hit(20'h00102, 1, "R8 keep2");

    // R6 flush removes all eight
    flush();
    for (int i = 2; i < 8; i++) expect_hit(20'h00100 + 20'(i), 0, "R6 all");
    // R8 pointer back at slot 0 after flush
    for (int i = 0; i < 8; i++) fill_ok(20'h00300 + 20'(i));
    fill_ok(20'h00400);
    expect_hit(20'h00300, 0, "R8 ptr reset");
    expect_hit(20'h00302, 1, "R8 ptr reset keep");

    // R7 single invalidate
    flush();
    for (int i = 0; i < 4; i++) fill_ok(20'h00500 + 20'(i));
    inval(20'h00502);
    for (int i = 0; i < 4; i++) expect_hit(20'h00500 + 20'(i), i != 2, "R7");
    inval(20'h00999);
    for (int i = 0; i < 4; i++) expect_hit(20'h00500 + 20'(i), i != 2, "R7 nomatch");

    // R9 collisions
    fill(20'h00600, 3'b111, 0, 1, 20'h00600, 0, f, pa);
    expect_hit(20'h00600, 0, "R9 inv same");
    fill(20'h00601, 3'b111, 0, 1, 20'h00501, 0, f, pa);
    expect_hit(20'h00601, 1, "R9 inv other keep new");
    expect_hit(20'h00501, 0, "R9 inv other removed");
    expect_hit(20'h00500, 1, "R9 untouched");
    fill(20'h00602, 3'b111, 0, 0, 0, 1, f, pa);
    expect_hit(20'h00602, 0, "R9 flush");
    expect_hit(20'h00500, 0, "R9 flush all");

    // R5 permission sweep
    for (int p = 0; p < 8; p++) begin
      fill(20'h00700 + 20'(p), 3'(p), 0, 0, 0, 0, f, pa);
      for (int a = 0; a < 8; a++) begin
        bit wr, us, wp, exp;
        wr = a[0]; us = a[1]; wp = a[2];
        exp = !p[0] || (us && !p[2]) || (wr && !p[1] && (us || wp));
        probe(20'h00700 + 20'(p), 12'h044, wr, us, wp, h, f, pa, w);
        chk(h == 1 && w == 0, "R5 hit no walk", {30'd0, h, w}, 32'd2);
        chk(f == exp, "R5 fault", {24'd0, 3'(p), 1'b0, a[3:0]} | {31'd0, f}, {31'd0, exp});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule